// File: doc/BRIEF.md
# Two-Pattern March Memory Tester

This block is a built-in self-test controller for a word-wide synchronous memory. Once started, it walks a fixed address range with two complementary alternating-bit patterns (bit i set for even i, then the same word inverted). Each round opens with a fill pass that writes the round's base pattern everywhere. An ascending sweep follows, then a descending sweep. Every word is visited in one read-modify-write slot: a read cycle, then a compare cycle that writes the complement back only when the word held what was expected. The descending sweep starts by re-reading the highest word. When it reaches word zero, the round is repeated with the two patterns swapped.

The controller keeps a result set: a saturating mismatch count, the address, expected word and actual word of the first mismatch, and an OR of expected XOR actual over all mismatches. The OR shows a single stuck data line as a single set bit, which separates it from wider faults. With the stop-on-error mode latched at start, the run halts at the first mismatch. Otherwise it runs to the end and counts every mismatch. The memory port has no back-pressure: the memory must take one access per cycle and return read data exactly one cycle after the read strobe. For that reason the memory side is a plain strobe interface and has no valid/ready handshake.

Top module: `march_bist`

## Requirements
- R1: While reset is held and after it is released, done is low, no read strobe or write enable is asserted, and the mismatch count and bit accumulator are zero.
- R2: A start pulse accepted while idle or done begins a fill pass in the next cycle. The fill pass writes the base pattern to addresses 0 through LAST_ADDR in ascending order, one word per cycle. In the first round the base pattern is 0x5555 for 16-bit words, that is, bit i is set for even i.
- R3: The ascending sweep reads each address from 0 to LAST_ADDR. In the following cycle it compares the read data with the base pattern and, on a match, writes the complement to the same address. The read strobe and the write enable are never high in the same cycle.
- R4: After the read at LAST_ADDR, the descending sweep reads from LAST_ADDR down to 0. It checks each word for the complement and, on a match, rewrites the base pattern.
- R5: When the descending sweep finishes word 0 in the first round, a second round repeats the fill pass and both sweeps with the base pattern 0xAAAA (bit i set for odd i) and complement 0x5555.
- R6: A mismatch suppresses the write for that word and adds one to the mismatch count. The count saturates at its all-ones value.
- R7: The address, expected word and actual word of the first mismatch since start are captured and then held through the rest of the run.
- R8: The bit accumulator is the OR of expected XOR actual over every mismatch since start.
- R9: With stop-on-error set at start, the run ends at the first mismatch and no further memory access follows.
- R10: done goes high only after the second round's descending sweep ends, or at the halting mismatch in R9. done and the results then hold until the next accepted start. pass is high while done is high and the count is zero. A start pulse during a run is ignored.
- R11: No access is ever made to an address above LAST_ADDR, including when LAST_ADDR + 1 is not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to begin a run |
| stop_on_error | input | 1 | Latched at start: halt at the first mismatch |
| mem_addr | output | ADDR_W | Word address to the memory |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata one cycle later |
| mem_wr | output | 1 | Write enable |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data from the memory |
| done | output | 1 | Run finished; results are valid |
| pass | output | 1 | done with no mismatch |
| err_count | output | CNT_W | Saturating mismatch count |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_expect | output | DATA_W | Word expected at the first mismatch |
| fail_actual | output | DATA_W | Word read at the first mismatch |
| fail_bits | output | DATA_W | OR of expected XOR actual over all mismatches |

## Verification
The bench builds the block with 4 address bits, a range ending at word 12 and a 2-bit mismatch counter. This keeps every run to 130 memory operations, and the non-power-of-two end proves that the range limit is honoured. A bench-side memory injects a stuck-at-0 or stuck-at-1 cell at every address and on several data lines, in both halting and counting mode. Each run's full operation stream and result set is compared with an arithmetic model of the march. Two simultaneous faults push the count past three, which exercises saturation, and a start pulse is injected mid-run to show that it is ignored.

// File: rtl/march_pkg.sv
package march_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_RD,
    ST_CHK,
    ST_DONE
  } march_st_t;
endpackage

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int LAST_ADDR = (1 << 18) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop_on_error,
  input  logic              mismatch,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              chk_valid,
  output logic [DATA_W-1:0] chk_expect,
  output logic              run_start,
  output logic              done
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(LAST_ADDR);

  function automatic logic [DATA_W-1:0] even_ones();
    logic [DATA_W-1:0] v;
    for (int i = 0; i < DATA_W; i++) v[i] = (i % 2 == 0);
    return v;
  endfunction

  localparam logic [DATA_W-1:0] PAT_EVEN = even_ones();

  march_st_t         st;
  logic [ADDR_W-1:0] addr;
  logic              round_q;
  logic              down_q;
  logic              stop_q;
  logic [DATA_W-1:0] base;

  assign base      = round_q ? ~PAT_EVEN : PAT_EVEN;
  assign run_start = start && (st == ST_IDLE || st == ST_DONE);

  always_comb begin
    mem_addr   = addr;
    mem_rd     = (st == ST_RD);
    chk_valid  = (st == ST_CHK);
    chk_expect = down_q ? ~base : base;
    mem_wr     = (st == ST_FILL) || (st == ST_CHK && !mismatch);
    mem_wdata  = (st == ST_FILL) ? base : ((st == ST_CHK) ? ~chk_expect : '0);
    done       = (st == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      addr    <= '0;
      round_q <= 1'b0;
      down_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            st      <= ST_FILL;
            addr    <= '0;
            round_q <= 1'b0;
            down_q  <= 1'b0;
            stop_q  <= stop_on_error;
          end
        end
        ST_FILL: begin
          if (addr == TOP_ADDR) begin
            addr <= '0;
            st   <= ST_RD;
          end else begin
            addr <= addr + ADDR_W'(1);
          end
        end
        ST_RD: st <= ST_CHK;
        ST_CHK: begin
          if (mismatch && stop_q) begin
            st <= ST_DONE;
          end else if (!down_q) begin
            if (addr == TOP_ADDR) down_q <= 1'b1;
            else addr <= addr + ADDR_W'(1);
            st <= ST_RD;
          end else if (addr != '0) begin
            addr <= addr - ADDR_W'(1);
            st   <= ST_RD;
          end else if (round_q) begin
            st <= ST_DONE;
          end else begin
            round_q <= 1'b1;
            down_q  <= 1'b0;
            st      <= ST_FILL;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: a strobe and a write never share a cycle
  assert_rd_wr_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R3: the write-back of a visit lands on the word just read
  assert_writeback_same_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_rd)) |-> (mem_addr == $past(mem_addr)));

  // R11: accesses stay inside the configured range
  assert_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_addr <= TOP_ADDR));

  // R10: done holds until a new start
  assert_done_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R9: no memory traffic once finished
  assert_quiet_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(mem_rd || mem_wr));
endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              chk_valid,
  input  logic [DATA_W-1:0] chk_expect,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              mismatch,
  output logic [CNT_W-1:0]  err_count,
  output logic [ADDR_W-1:0] first_addr,
  output logic [DATA_W-1:0] first_expect,
  output logic [DATA_W-1:0] first_actual,
  output logic [DATA_W-1:0] err_bits
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign mismatch = chk_valid && (rd_data != chk_expect);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      err_count    <= '0;
      first_addr   <= '0;
      first_expect <= '0;
      first_actual <= '0;
      err_bits     <= '0;
    end else if (mismatch) begin
      if (err_count != CNT_MAX) err_count <= err_count + CNT_W'(1);
      if (err_count == '0) begin
        first_addr   <= chk_addr;
        first_expect <= chk_expect;
        first_actual <= rd_data;
      end
      err_bits <= err_bits | (chk_expect ^ rd_data);
    end
  end

  // R6: the count never falls during a run
  assert_count_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (err_count >= $past(err_count)));

  // R7: first-failure record frozen once taken
  assert_first_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != '0 && !clear) |=> ($stable(first_addr) && $stable(first_expect) && $stable(first_actual)));

  // R8: accumulator is empty exactly when no mismatch was counted
  assert_bits_track_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == '0) == (err_bits == '0));
endmodule

// File: rtl/march_bist.sv
module march_bist #(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int LAST_ADDR = (1 << 18) - 1,
  parameter int CNT_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop_on_error,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              pass,
  output logic [CNT_W-1:0]  err_count,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_expect,
  output logic [DATA_W-1:0] fail_actual,
  output logic [DATA_W-1:0] fail_bits
);
  logic              mismatch;
  logic              chk_valid;
  logic [DATA_W-1:0] chk_expect;
  logic              run_start;

  march_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAST_ADDR(LAST_ADDR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop_on_error(stop_on_error),
    .mismatch(mismatch), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .chk_valid(chk_valid), .chk_expect(chk_expect),
    .run_start(run_start), .done(done)
  );

  march_cmp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(run_start), .chk_valid(chk_valid),
    .chk_expect(chk_expect), .rd_data(mem_rdata), .chk_addr(mem_addr),
    .mismatch(mismatch), .err_count(err_count), .first_addr(fail_addr),
    .first_expect(fail_expect), .first_actual(fail_actual), .err_bits(fail_bits)
  );

  assign pass = done && (err_count == '0);

  // R1: idle and quiet straight after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!done && !mem_rd && !mem_wr && err_count == '0));
endmodule

// File: tb/march_bist_test.sv
`timescale 1ns/1ps
module march_bist_test;
  localparam int AW = 4, DW = 16, LAST = 12, CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop_on_error = 1'b0;
  logic [AW-1:0] mem_addr, fail_addr;
  logic mem_rd, mem_wr, done, pass;
  logic [DW-1:0] mem_wdata, fail_expect, fail_actual, fail_bits;
  logic [DW-1:0] mem_rdata = '0;
  logic [CW-1:0] err_count;

  always #4 clk = ~clk;

  march_bist #(.ADDR_W(AW), .DATA_W(DW), .LAST_ADDR(LAST), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop_on_error(stop_on_error),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .pass(pass), .err_count(err_count),
    .fail_addr(fail_addr), .fail_expect(fail_expect), .fail_actual(fail_actual),
    .fail_bits(fail_bits)
  );

  int checks = 0, errors = 0;

  // stuck-cell fault model
  logic [AW-1:0] f_addr [2];
  logic [DW-1:0] f_mask [2];
  bit f_val [2];
  bit f_en [2] = '{0, 0};

  function automatic logic [DW-1:0] stored(logic [AW-1:0] a, logic [DW-1:0] w);
    logic [DW-1:0] r = w;
    for (int k = 0; k < 2; k++)
      if (f_en[k] && f_addr[k] == a) r = f_val[k] ? (r | f_mask[k]) : (r & ~f_mask[k]);
    return r;
  endfunction

  logic [DW-1:0] mem [0:15];
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= stored(mem_addr, mem_wdata);
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  // operation log seen at the ports
  int d_kind [512]; int d_addr [512]; logic [DW-1:0] d_data [512];
  int d_n = 0, d_both = 0, d_oob = 0;
  bit logging = 0;
  always @(negedge clk) if (logging) begin
    if (mem_rd && mem_wr) d_both++;
    if ((mem_rd || mem_wr) && int'(mem_addr) > LAST) d_oob++;
    if (mem_wr && d_n < 512) begin d_kind[d_n] = 1; d_addr[d_n] = int'(mem_addr); d_data[d_n] = mem_wdata; d_n++; end
    else if (mem_rd && d_n < 512) begin d_kind[d_n] = 0; d_addr[d_n] = int'(mem_addr); d_data[d_n] = '0; d_n++; end
  end

  // arithmetic model of the march
  int r_kind [512]; int r_addr [512]; logic [DW-1:0] r_data [512]; string r_tag [512];
  int r_n, e_cnt;
  logic [AW-1:0] e_addr; logic [DW-1:0] e_exp, e_act, e_bits;

  task automatic push(int k, int a, logic [DW-1:0] d, string t);
    r_kind[r_n] = k; r_addr[r_n] = a; r_data[r_n] = d; r_tag[r_n] = t; r_n++;
  endtask

  task automatic note_err(int a, logic [DW-1:0] ex, logic [DW-1:0] ac);
    if (e_cnt == 0) begin e_addr = AW'(a); e_exp = ex; e_act = ac; end
    e_cnt++;
    e_bits |= ex ^ ac;
  endtask

  task automatic ref_run(bit stop);
    logic [DW-1:0] rm [0:15];
    logic [DW-1:0] base, act;
    bit halt = 0;
    r_n = 0; e_cnt = 0; e_bits = '0; e_addr = '0; e_exp = '0; e_act = '0;
    for (int r = 0; r < 2 && !halt; r++) begin
      base = (r == 0) ? 16'h5555 : 16'hAAAA;
      for (int a = 0; a <= LAST; a++) begin
        push(1, a, base, r == 0 ? "R2" : "R5");
        rm[a] = stored(AW'(a), base);
      end
      for (int a = 0; a <= LAST && !halt; a++) begin
        push(0, a, '0, r == 0 ? "R3" : "R5");
        act = rm[a];
        if (act == base) begin push(1, a, ~base, r == 0 ? "R3" : "R5"); rm[a] = stored(AW'(a), ~base); end
        else begin note_err(a, base, act); if (stop) halt = 1; end
      end
      for (int a = LAST; a >= 0 && !halt; a--) begin
        push(0, a, '0, r == 0 ? "R4" : "R5");
        act = rm[a];
        if (act == ~base) begin push(1, a, base, r == 0 ? "R4" : "R5"); rm[a] = stored(AW'(a), base); end
        else begin note_err(a, ~base, act); if (stop) halt = 1; end
      end
    end
  endtask

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_case(bit stop, bit poke);
    int cyc, mis;
    longint exp_cnt;
    ref_run(stop);
    d_n = 0; d_both = 0; d_oob = 0; logging = 1;
    @(negedge clk); stop_on_error = stop; start = 1;
    @(negedge clk); start = 0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk); cyc++;
      start = (poke && cyc == 25);
    end
    start = 0;
    check(done === 1'b1, "R10 done reached", longint'(done), 1);
    repeat (4) @(negedge clk);
    logging = 0;
    check(done === 1'b1, "R10 done held", longint'(done), 1);
    check(d_n == r_n, stop ? "R9 op count" : "R10 op count", d_n, r_n);
    mis = -1;
    for (int i = 0; i < r_n && i < d_n; i++)
      if (mis < 0 && (d_kind[i] != r_kind[i] || d_addr[i] != r_addr[i] || d_data[i] != r_data[i])) mis = i;
    if (mis >= 0)
      check(0, {r_tag[mis], " op stream"}, longint'({d_kind[mis][3:0], d_addr[mis][7:0], d_data[mis]}),
            longint'({r_kind[mis][3:0], r_addr[mis][7:0], r_data[mis]}));
    else check(1, "R3 op stream", 0, 0);
    check(d_both == 0, "R3 rd/wr overlap", d_both, 0);
    check(d_oob == 0, "R11 range", d_oob, 0);
    exp_cnt = (e_cnt > 3) ? 3 : e_cnt;
    check(longint'(err_count) == exp_cnt, e_cnt > 3 ? "R6 saturate" : "R6 count", err_count, exp_cnt);
    check(pass == (e_cnt == 0), "R10 pass", pass, e_cnt == 0);
    check(fail_bits == e_bits, "R8 bits", fail_bits, e_bits);
    if (e_cnt > 0) begin
      check(fail_addr == e_addr, "R7 addr", fail_addr, e_addr);
      check(fail_expect == e_exp, "R7 expect", fail_expect, e_exp);
      check(fail_actual == e_act, "R7 actual", fail_actual, e_act);
    end
  endtask

  int bit_list [5] = '{0, 1, 7, 14, 15};

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !mem_rd && !mem_wr, "R1 quiet in reset", {done, mem_rd, mem_wr}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!done && !mem_rd && !mem_wr, "R1 quiet after reset", {done, mem_rd, mem_wr}, 0);
    check(err_count == 0 && fail_bits == 0, "R1 results clear", fail_bits, 0);

    run_case(0, 0);             // clean, counting
    run_case(1, 0);             // clean, halting
    run_case(0, 1);             // R10: start mid-run ignored

    for (int fa = 0; fa <= LAST; fa++)
      for (int bi = 0; bi < 5; bi++)
        for (int v = 0; v < 2; v++)
          for (int s = 0; s < 2; s++) begin
            f_en[0] = 1; f_addr[0] = AW'(fa); f_mask[0] = DW'(1) << bit_list[bi]; f_val[0] = (v == 1);
            f_en[1] = 0;
            run_case(s == 1, 0);
          end

    // R6: two faulty cells push the count past its maximum
    f_en[0] = 1; f_addr[0] = 4'd2; f_mask[0] = 16'h0008; f_val[0] = 1;
    f_en[1] = 1; f_addr[1] = 4'd9; f_mask[1] = 16'h0010; f_val[1] = 0;
    run_case(0, 0);
    f_en[0] = 0; f_en[1] = 0;
    run_case(0, 0);             // results cleared by a fresh start

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule